// File: doc/BRIEF.md
# Raster LCD Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel clock for a TFT raster panel, along with the column and row position of the current pixel. Software programs it through a small write port. There are two packed timing words, one optional word of wide-mode high bits, a control word and a clock divisor. Each line goes through its active pixels, then front porch, sync pulse and back porch. Lines in a frame follow the same order.

Timing values are copied into shadow registers at the start of each frame. A write during a frame therefore only takes effect at the next frame. Clearing the enable bit lets the current frame finish. The block then goes idle and sets a sticky frame-complete flag, which software clears by writing a one.

Top module: `lcd_raster_timing`

## Requirements
- R1: After reset the outputs are idle: `de` = 0, `active` = 0, `frame_done` = 0, `pix_x` = `pix_y` = 0, and `hsync`, `vsync` and `pclk` sit at their deasserted levels.
- R2: Word 0 (address 0) bits 9:4 hold the line width in units of 16 pixels minus one, so active pixels per line = (field+1)*16. In wide mode (control bit 4), bit 3 of word 0 is one more high bit of that field.
- R3: Word 0 holds the horizontal back porch in bits 31:24, front porch in bits 23:16 and sync width in bits 15:10, all in pixels. A zero value gives one pixel. Each line runs active, front porch, sync, back porch, and `pix_x` counts up by one per pixel from 0.
- R4: Word 1 (address 1) holds the active line count minus one in bits 9:0, back porch in bits 31:24, front porch in bits 23:16 and sync width in bits 15:10, all in lines (zero gives one). Lines run in the same order, and `pix_y` counts them.
- R5: Word 2 (address 2) bits 1:0 extend the horizontal front porch to 10 bits, bits 5:4 extend the back porch, and bits 30:27 extend the sync width. These bits and bit 3 of word 0 are used only while control bit 4 is set.
- R6: `de` is high only while both counters are in their active regions and the block is running.
- R7: Before inversion, hsync and vsync are active high. Control bits 1 and 2 (address 3) invert them.
- R8: The divisor (address 4) sets the pixel period in clock cycles, and values 0 and 1 act as 2. `pclk` is high for the last ceil(D/2) cycles of each pixel, and control bit 3 inverts it.
- R9: Timing words and divisor written during a frame are used from the next frame start on.
- R10: Control bit 0 enables the raster. From idle it starts a frame at pixel 0, line 0 on the next cycle. When it is cleared, the current frame finishes, and in the cycle where `active` falls `frame_done` is set.
- R11: `frame_done` stays set until a write of 1 to bit 0 at address 5. Writing 0 there leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pclk | output | 1 | Divided pixel clock |
| hsync | output | 1 | Line sync after polarity |
| vsync | output | 1 | Frame sync after polarity |
| de | output | 1 | Data enable |
| pix_x | output | 13 | Pixel position in line |
| pix_y | output | 13 | Line position in frame |
| active | output | 1 | Raster running |
| frame_done | output | 1 | Sticky frame-complete flag |

## Verification
The assertions check several rules on every cycle:
- the block is quiet while idle;
- data-enable never overlaps a sync pulse;
- `pix_x` steps by one or wraps to zero;
- a frame starts at the origin;
- `frame_done` rises only as the raster stops and then holds until cleared.

Other behaviours can only be shown by the bench's scenarios. These are the exact phase lengths decoded from the packed fields, the wide-mode extension, divisor clamping, and the deferred use of timing writes. The bench compares whole-frame counts and the pixel position at every sample against values it computes from the field values.

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic             pclk,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] pix_y,
  output logic             active,
  output logic             frame_done
);
  localparam logic [2:0] A_T0 = 3'd0, A_T1 = 3'd1, A_T2 = 3'd2,
                         A_CTL = 3'd3, A_DIV = 3'd4, A_STS = 3'd5;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [31:0] t0_q, t1_q, t2_q;
  logic [4:0]  ctl_q;
  logic [DIV_W-1:0] div_q;

  function automatic logic [CNT_W-1:0] nz(input logic [CNT_W-1:0] x);
    return (x == '0) ? ONE : x;
  endfunction

  wire wide = ctl_q[4];
  wire [6:0] ppl_f = {wide & t0_q[3], t0_q[9:4]};
  wire [9:0] hfp_f = {wide ? t2_q[1:0] : 2'b00, t0_q[23:16]};
  wire [9:0] hbp_f = {wide ? t2_q[5:4] : 2'b00, t0_q[31:24]};
  wire [9:0] hsw_f = {wide ? t2_q[30:27] : 4'b0000, t0_q[15:10]};

  wire [CNT_W-1:0] w_n   = (CNT_W'(ppl_f) + ONE) << 4;
  wire [CNT_W-1:0] hfe_n = w_n + nz(CNT_W'(hfp_f));
  wire [CNT_W-1:0] hse_n = hfe_n + nz(CNT_W'(hsw_f));
  wire [CNT_W-1:0] ht_n  = hse_n + nz(CNT_W'(hbp_f));
  wire [CNT_W-1:0] va_n  = CNT_W'(t1_q[9:0]) + ONE;
  wire [CNT_W-1:0] vfe_n = va_n + nz(CNT_W'(t1_q[23:16]));
  wire [CNT_W-1:0] vse_n = vfe_n + nz(CNT_W'(t1_q[15:10]));
  wire [CNT_W-1:0] vt_n  = vse_n + nz(CNT_W'(t1_q[31:24]));
  wire [DIV_W-1:0] div_n = (div_q < DIV_W'(2)) ? DIV_W'(2) : div_q;

  logic [CNT_W-1:0] w_s, hfe_s, hse_s, ht_s, va_s, vfe_s, vse_s, vt_s;
  logic [DIV_W-1:0] div_s, dcnt;
  logic [CNT_W-1:0] hcnt, vcnt;
  logic run_q, done_q;

  wire pix_en    = run_q && (dcnt == div_s - DIV_W'(1));
  wire line_end  = (hcnt == ht_s - ONE);
  wire frame_end = line_end && (vcnt == vt_s - ONE);
  wire load      = (!run_q && ctl_q[0]) || (pix_en && frame_end && ctl_q[0]);
  wire stop      = pix_en && frame_end && !ctl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_q <= '0; t1_q <= '0; t2_q <= '0; ctl_q <= '0; div_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_T0:  t0_q  <= wr_data;
        A_T1:  t1_q  <= wr_data;
        A_T2:  t2_q  <= wr_data;
        A_CTL: ctl_q <= wr_data[4:0];
        A_DIV: div_q <= wr_data[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_s <= '0; hfe_s <= '0; hse_s <= '0; ht_s <= ONE;
      va_s <= '0; vfe_s <= '0; vse_s <= '0; vt_s <= ONE;
      div_s <= DIV_W'(2);
    end else if (load) begin
      w_s <= w_n; hfe_s <= hfe_n; hse_s <= hse_n; ht_s <= ht_n;
      va_s <= va_n; vfe_s <= vfe_n; vse_s <= vse_n; vt_s <= vt_n;
      div_s <= div_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; dcnt <= '0; hcnt <= '0; vcnt <= '0;
    end else if (!run_q) begin
      dcnt <= '0; hcnt <= '0; vcnt <= '0;
      run_q <= ctl_q[0];
    end else begin
      dcnt <= pix_en ? '0 : dcnt + DIV_W'(1);
      if (pix_en) begin
        if (line_end) begin
          hcnt <= '0;
          vcnt <= frame_end ? '0 : vcnt + ONE;
          if (stop) run_q <= 1'b0;
        end else begin
          hcnt <= hcnt + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else if (stop) done_q <= 1'b1;
    else if (wr_en && wr_addr == A_STS && wr_data[0]) done_q <= 1'b0;
  end

  wire h_act = hcnt < w_s;
  wire v_act = vcnt < va_s;
  wire h_syn = (hcnt >= hfe_s) && (hcnt < hse_s);
  wire v_syn = (vcnt >= vfe_s) && (vcnt < vse_s);

  assign de         = run_q && h_act && v_act;
  assign hsync      = (run_q && h_syn) ^ ctl_q[1];
  assign vsync      = (run_q && v_syn) ^ ctl_q[2];
  assign pclk       = (run_q && (dcnt >= (div_s >> 1))) ^ ctl_q[3];
  assign pix_x      = hcnt;
  assign pix_y      = vcnt;
  assign active     = run_q;
  assign frame_done = done_q;
endmodule

// File: rtl/lcd_raster_timing_chk.sv
module lcd_raster_timing_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             de,
  input logic             hsync,
  input logic             vsync,
  input logic             frame_done,
  input logic [CNT_W-1:0] pix_x,
  input logic [CNT_W-1:0] pix_y,
  input logic             inv_h,
  input logic             inv_v,
  input logic             clr
);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!de && pix_x == '0 && pix_y == '0));

  assert_idle_sync_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (hsync == inv_h && vsync == inv_v));

  assert_de_not_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == inv_h && vsync == inv_v));

  assert_x_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && pix_x != $past(pix_x))
      |-> (pix_x == $past(pix_x) + CNT_W'(1) || pix_x == '0));

  assert_start_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (pix_x == '0 && pix_y == '0));

  assert_done_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> frame_done);

  assert_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> $fell(active));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !clr) |=> frame_done);
endmodule

bind lcd_raster_timing lcd_raster_timing_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .de(de), .hsync(hsync),
  .vsync(vsync), .frame_done(frame_done), .pix_x(pix_x), .pix_y(pix_y),
  .inv_h(ctl_q[1]), .inv_v(ctl_q[2]),
  .clr(wr_en && wr_addr == 3'd5 && wr_data[0])
);

// File: tb/lcd_raster_timing_test.sv
module lcd_raster_timing_test;
  localparam int PERIOD = 10;
  localparam int CW = 13;
  localparam int NV = 6;
  // w16, lines, hfp, hsw, hbp, vfp, vsw, vbp, div, ctrl
  localparam int VEC [NV][10] = '{
    '{1,  2, 2,   3,  4,   1, 2, 1, 2, 0},
    '{2,  3, 0,   1,  0,   0, 0, 2, 0, 6},
    '{1,  1, 5,   7,  1,   2, 1, 3, 5, 8},
    '{65, 1, 260, 70, 300, 1, 1, 1, 1, 16},
    '{65, 1, 260, 70, 300, 1, 1, 1, 1, 0},
    '{1,  2, 1,   1,  1,   1, 1, 1, 3, 4}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic pclk, hsync, vsync, de, active, frame_done;
  logic [CW-1:0] pix_x, pix_y;
  int n_chk = 0, n_bad = 0;
  int n_act, n_de, n_hs, n_vs, n_pc, pos_bad;

  always #(PERIOD/2) clk = ~clk;

  lcd_raster_timing uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pclk(pclk), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .active(active), .frame_done(frame_done));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic int nz(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  // Enable, run, disable after mod_at samples (optionally writing new word 0 first).
  task automatic run(input int ctrl, input int mod_at, input bit do_mod, input int mod_t0,
                     input int ht, input int d);
    int i;
    n_act = 0; n_de = 0; n_hs = 0; n_vs = 0; n_pc = 0; pos_bad = 0; i = 0;
    wr(3, ctrl | 1);
    if (mod_at == 0) begin wr_en = 1; wr_addr = 3; wr_data = 32'(ctrl); end
    while (!frame_done && i < 100000) begin
      @(negedge clk);
      wr_en = 0;
      if (do_mod && i == mod_at) begin wr_en = 1; wr_addr = 0; wr_data = 32'(mod_t0); end
      if (mod_at != 0 && i == mod_at + 1) begin wr_en = 1; wr_addr = 3; wr_data = 32'(ctrl); end
      if (active) begin
        int p;
        p = n_act / d;
        if (int'(pix_x) != p % ht || int'(pix_y) != p / ht) pos_bad++;
        n_act++;
        if (de) n_de++;
        if (hsync != ctrl[1]) n_hs++;
        if (vsync != ctrl[2]) n_vs++;
        if (pclk != ctrl[3]) n_pc++;
      end
      i++;
    end
    wr_en = 0;
    check(i < 100000, "R10 frame completion timeout", i, 100000);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!de && !active && !frame_done && pix_x == 0 && pix_y == 0, "R1 idle outputs", int'(de), 0);
    check(hsync == 0 && vsync == 0 && pclk == 0, "R1 sync levels", int'({hsync, vsync, pclk}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!active && !frame_done, "R1 stays idle after reset", int'(active), 0);

    for (int v = 0; v < NV; v++) begin
      int w16, lines, hfp, hsw, hbp, vfp, vsw, vbp, dv, ctl, d, wd;
      int ew, efp, esw, ebp, ht, vt, t0, t1, t2;
      w16 = VEC[v][0]; lines = VEC[v][1]; hfp = VEC[v][2]; hsw = VEC[v][3];
      hbp = VEC[v][4]; vfp = VEC[v][5]; vsw = VEC[v][6]; vbp = VEC[v][7];
      dv = VEC[v][8]; ctl = VEC[v][9];
      t0 = ((hbp & 255) << 24) | ((hfp & 255) << 16) | ((hsw & 63) << 10)
         | (((w16 - 1) & 63) << 4) | ((((w16 - 1) >> 6) & 1) << 3);
      t1 = (vbp << 24) | (vfp << 16) | (vsw << 10) | (lines - 1);
      t2 = ((hfp >> 8) & 3) | (((hbp >> 8) & 3) << 4) | (((hsw >> 6) & 15) << 27);
      wd = (ctl >> 4) & 1;
      ew  = wd ? w16 * 16 : (((w16 - 1) & 63) + 1) * 16;
      efp = nz(wd ? hfp : hfp & 255);
      esw = nz(wd ? hsw : hsw & 63);
      ebp = nz(wd ? hbp : hbp & 255);
      ht = ew + efp + esw + ebp;
      vt = lines + nz(vfp) + nz(vsw) + nz(vbp);
      d = (dv < 2) ? 2 : dv;
      wr(0, t0); wr(1, t1); wr(2, t2); wr(4, dv);
      run(ctl, 0, 0, 0, ht, d);
      check(n_act == ht * vt * d, "R3 R4 R8 frame length", n_act, ht * vt * d);
      check(n_de == ew * lines * d, "R2 R5 R6 data-enable count", n_de, ew * lines * d);
      check(n_hs == esw * vt * d, "R3 R5 R7 hsync width", n_hs, esw * vt * d);
      check(n_vs == nz(vsw) * ht * d, "R4 R7 vsync width", n_vs, nz(vsw) * ht * d);
      check(n_pc == ht * vt * (d - d / 2), "R8 pclk duty", n_pc, ht * vt * (d - d / 2));
      check(pos_bad == 0, "R3 R4 R10 pixel position", pos_bad, 0);
      check(frame_done && !active && !de && pix_x == 0 && pix_y == 0, "R10 stop state",
            int'(active), 0);
      check(hsync == ctl[1] && vsync == ctl[2] && pclk == ctl[3], "R7 R8 idle polarity",
            int'({hsync, vsync, pclk}), ctl[3:1]);
      wr(5, 1);
    end

    // R11 sticky flag
    wr(0, (4 << 24) | (2 << 16) | (3 << 10)); wr(1, (1 << 24) | (1 << 16) | (2 << 10) | 1);
    wr(2, 0); wr(4, 2);
    run(0, 0, 0, 0, 25, 2);
    check(frame_done == 1, "R11 flag set after stop", int'(frame_done), 1);
    wr(5, 0);
    repeat (3) @(negedge clk);
    check(frame_done == 1, "R11 write 0 keeps flag", int'(frame_done), 1);
    wr(5, 1);
    check(frame_done == 0, "R11 write 1 clears flag", int'(frame_done), 0);

    // R9 deferred timing write: width 16 -> 32 written mid-frame
    run(0, 50, 1, (4 << 24) | (2 << 16) | (3 << 10) | (1 << 4), 25, 2);
    check(n_act == 300, "R9 current frame keeps old width", n_act, 300);
    wr(5, 1);
    run(0, 0, 0, 0, 41, 2);
    check(n_act == 492, "R9 next frame uses new width", n_act, 492);
    check(pos_bad == 0, "R9 R2 positions with new width", pos_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule